// File: doc/BRIEF.md
# LCD Panel Power Sequencer

This block brings an LCD panel up and down in a safe order. It has three outputs that follow one another. The first is a logic-supply enable. The second is an output enable that lets the pixel data bus and the four panel timing lines through (frame marker, line clock, shift clock, display enable). The third is a drive-voltage enable. On the way up these three turn on in that order. On the way down they turn off in the reverse order.

Each gap between two steps is a whole number of frames. The block counts frames on a one-cycle `frame_tick` input. A 16-bit period word holds four 4-bit fields. A field value N gives a gap of N+1 frames, so each gap can be 1 to 16 frames. The level input `disp_req` asks for the display to be on (1) or off (0).

The block does not produce pixel data or panel timing. It only gates those signals and orders the two supplies around them.

Top module: `lcd_pwr_seq`

## Requirements
- R1: While reset is asserted, and after it, until a request arrives: both supply enables, `out_en` and `busy` are low, and all gated outputs are 0.
- R2: Power-on steps through three states, each on its own clock edge and never two at once: first `logic_pwr_en` goes high, then `out_en`, then `drive_pwr_en`.
- R3: Field `seq_periods[15:12]` (value N) sets the power-on first gap. `out_en` rises at the (N+1)-th frame tick after the edge where `logic_pwr_en` rose.
- R4: Field `seq_periods[11:8]` (value N) sets the power-on second gap. `drive_pwr_en` rises at the (N+1)-th frame tick after the edge where `out_en` rose.
- R5: When `disp_req` falls while the block is fully on, the steps run in reverse, and the first step comes on the next edge. `drive_pwr_en` falls. After field `seq_periods[7:4]`+1 ticks, `out_en` falls. After field `seq_periods[3:0]`+1 further ticks, `logic_pwr_en` falls.
- R6: `pix_out`, `frm_out`, `lclk_out`, `sclk_out` and `den_out` equal their inputs while `out_en` is high, and are 0 otherwise.
- R7: All four fields are taken when a sequence starts. A change to `seq_periods` during a running sequence has no effect on that sequence's gaps.
- R8: A change of `disp_req` to the opposite value during a sequence does not cut it short. The running sequence completes, and the opposite sequence then starts on the next edge.
- R9: `busy` is high exactly while a sequence is in progress. It is low when fully off (all enables low) or fully on (all enables high).
- R10: Apart from the first step of a sequence, no enable changes on an edge where `frame_tick` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame |
| disp_req | input | 1 | 1 = display on wanted, 0 = off wanted |
| seq_periods | input | 16 | Four period fields, each period minus one |
| pix_in | input | 16 | Pixel data from the display controller |
| frm_in | input | 1 | Frame marker in |
| lclk_in | input | 1 | Line clock in |
| sclk_in | input | 1 | Shift clock in |
| den_in | input | 1 | Display enable in |
| logic_pwr_en | output | 1 | Panel logic-supply enable |
| drive_pwr_en | output | 1 | Panel drive-voltage enable |
| out_en | output | 1 | Data and timing outputs enabled |
| busy | output | 1 | A sequence is in progress |
| pix_out | output | 16 | Gated pixel data |
| frm_out | output | 1 | Gated frame marker |
| lclk_out | output | 1 | Gated line clock |
| sclk_out | output | 1 | Gated shift clock |
| den_out | output | 1 | Gated display enable |

## Verification
Two events can land on the same edge, and the bench provokes both.

- A frame tick can arrive on the very edge that starts a sequence. Because ticks run freely, this happens. The reload must then win over the decrement, and the bench judges this by counting ticks between enable changes.
- The final step of one sequence can coincide with a reversed request. The bench drops `disp_req` just after power-on starts, and raises it again during power-off. It expects the running sequence to finish with its full frame counts, and the opposite sequence to begin on the following edge.

// File: rtl/lcd_pwr_pkg.sv
package lcd_pwr_pkg;
  typedef enum logic [2:0] {
    PS_OFF    = 3'd0,
    PS_UP_A   = 3'd1,
    PS_UP_B   = 3'd2,
    PS_ON     = 3'd3,
    PS_DN_A   = 3'd4,
    PS_DN_B   = 3'd5
  } pwr_state_t;

  function automatic logic is_wait(input pwr_state_t s);
    return (s == PS_UP_A) || (s == PS_UP_B) || (s == PS_DN_A) || (s == PS_DN_B);
  endfunction
endpackage

// File: rtl/lcd_frame_cnt.sv
module lcd_frame_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | dec;
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/lcd_pwr_fsm.sv
module lcd_pwr_fsm
  import lcd_pwr_pkg::*;
#(
  parameter int FLD_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_tick,
  input  logic             disp_req,
  input  logic [FLD_W-1:0] up_first,
  input  logic [FLD_W-1:0] up_second,
  input  logic [FLD_W-1:0] dn_first,
  input  logic [FLD_W-1:0] dn_second,
  input  logic             cnt_zero,
  output logic             cnt_load,
  output logic [FLD_W-1:0] cnt_val,
  output logic             cnt_dec,
  output pwr_state_t       state
);
  pwr_state_t       st_q, st_d;
  logic [FLD_W-1:0] hold_q, hold_d;
  logic             hold_en;
  logic             step;

  assign step = frame_tick & cnt_zero;

  always_comb begin
    st_d     = st_q;
    cnt_load = 1'b0;
    cnt_val  = hold_q;
    hold_en  = 1'b0;
    hold_d   = up_second;
    unique case (st_q)
      PS_OFF: if (disp_req) begin
        st_d     = PS_UP_A;
        cnt_load = 1'b1;
        cnt_val  = up_first;
        hold_en  = 1'b1;
        hold_d   = up_second;
      end
      PS_UP_A: if (step) begin
        st_d     = PS_UP_B;
        cnt_load = 1'b1;
        cnt_val  = hold_q;
      end
      PS_UP_B: if (step) st_d = PS_ON;
      PS_ON: if (!disp_req) begin
        st_d     = PS_DN_A;
        cnt_load = 1'b1;
        cnt_val  = dn_first;
        hold_en  = 1'b1;
        hold_d   = dn_second;
      end
      PS_DN_A: if (step) begin
        st_d     = PS_DN_B;
        cnt_load = 1'b1;
        cnt_val  = hold_q;
      end
      PS_DN_B: if (step) st_d = PS_OFF;
      default: st_d = PS_OFF;
    endcase
  end

  assign cnt_dec = frame_tick & ~cnt_zero & ~cnt_load & is_wait(st_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_OFF;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= '0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign state = st_q;
endmodule

// File: rtl/lcd_out_gate.sv
module lcd_out_gate #(
  parameter int N = 20
) (
  input  logic         en,
  input  logic [N-1:0] din,
  output logic [N-1:0] dout
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign dout[i] = din[i] & en;
  end
endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import lcd_pwr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLD_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 frame_tick,
  input  logic                 disp_req,
  input  logic [4*FLD_W-1:0]   seq_periods,
  input  logic [DATA_W-1:0]    pix_in,
  input  logic                 frm_in,
  input  logic                 lclk_in,
  input  logic                 sclk_in,
  input  logic                 den_in,
  output logic                 logic_pwr_en,
  output logic                 drive_pwr_en,
  output logic                 out_en,
  output logic                 busy,
  output logic [DATA_W-1:0]    pix_out,
  output logic                 frm_out,
  output logic                 lclk_out,
  output logic                 sclk_out,
  output logic                 den_out
);
  localparam int TIM_N  = 4;
  localparam int GATE_N = DATA_W + TIM_N;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             cnt_zero, cnt_load, cnt_dec;
  logic [FLD_W-1:0] cnt_val;
  pwr_state_t       state;
  logic [GATE_N-1:0] gate_in, gate_out;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lcd_pwr_fsm #(.FLD_W(FLD_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_tick (frame_tick),
    .disp_req   (disp_req),
    .up_first   (seq_periods[4*FLD_W-1 -: FLD_W]),
    .up_second  (seq_periods[3*FLD_W-1 -: FLD_W]),
    .dn_first   (seq_periods[2*FLD_W-1 -: FLD_W]),
    .dn_second  (seq_periods[FLD_W-1:0]),
    .cnt_zero   (cnt_zero),
    .cnt_load   (cnt_load),
    .cnt_val    (cnt_val),
    .cnt_dec    (cnt_dec),
    .state      (state)
  );

  lcd_frame_cnt #(.W(FLD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .dec      (cnt_dec),
    .zero     (cnt_zero)
  );

  always_comb begin
    logic_pwr_en = (state != PS_OFF);
    out_en       = (state == PS_UP_B) || (state == PS_ON) || (state == PS_DN_A);
    drive_pwr_en = (state == PS_ON);
    busy         = is_wait(state);
  end

  assign gate_in = {pix_in, frm_in, lclk_in, sclk_in, den_in};

  lcd_out_gate #(.N(GATE_N)) u_gate (
    .en   (out_en),
    .din  (gate_in),
    .dout (gate_out)
  );

  assign {pix_out, frm_out, lclk_out, sclk_out, den_out} = gate_out;
endmodule

// File: rtl/lcd_pwr_seq_chk.sv
module lcd_pwr_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_tick,
  input logic disp_req,
  input logic logic_pwr_en,
  input logic drive_pwr_en,
  input logic out_en,
  input logic busy
);
  // R2
  drive_needs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drive_pwr_en |-> (out_en && logic_pwr_en));
  // R2
  out_needs_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_en |-> logic_pwr_en);
  // R2
  out_after_logic_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(logic_pwr_en));
  // R2
  drive_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_pwr_en) |-> $past(out_en));
  // R5
  logic_off_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_pwr_en) |-> $past(!out_en));
  // R10
  out_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en) |-> $past(frame_tick));
  // R10
  drive_rise_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_pwr_en) |-> $past(frame_tick));
  // R10
  out_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en) |-> $past(frame_tick));
  // R10
  logic_fall_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(logic_pwr_en) |-> $past(frame_tick));
  // R8
  start_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(logic_pwr_en) |-> ($past(disp_req) && busy));
  // R8
  stop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drive_pwr_en) |-> ($past(!disp_req) && busy));
endmodule

bind lcd_pwr_seq lcd_pwr_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_tick   (frame_tick),
  .disp_req     (disp_req),
  .logic_pwr_en (logic_pwr_en),
  .drive_pwr_en (drive_pwr_en),
  .out_en       (out_en),
  .busy         (busy)
);

// File: tb/sim_lcd_pwr_seq.sv
`timescale 1ns/1ps
module sim_lcd_pwr_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_tick = 1'b0;
  logic        disp_req = 1'b0;
  logic [15:0] seq_periods = '0;
  logic [15:0] pix_in = 16'h0;
  logic        frm_in = 1'b0, lclk_in = 1'b0, sclk_in = 1'b0, den_in = 1'b0;
  logic        logic_pwr_en, drive_pwr_en, out_en, busy;
  logic [15:0] pix_out;
  logic        frm_out, lclk_out, sclk_out, den_out;

  always #4 clk = ~clk;

  lcd_pwr_seq u0 (.*);

  typedef struct {logic [2:0] t; int d; int r;} exp_t;
  exp_t exp_q[$];
  int checks = 0, fails = 0, ticks = 0, last_tk = 0, phase = 0;
  logic [2:0] prev = 3'b000;

  task automatic push(input logic [2:0] t, input int d, input int r);
    exp_t e;
    e.t = t; e.d = d; e.r = r;
    exp_q.push_back(e);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // monitor and frame ticker share one process so order is fixed
  always @(negedge clk) begin
    logic [2:0] cur;
    if (rst_n) begin
      cur = {drive_pwr_en, out_en, logic_pwr_en};
      // R6 gating
      checks++;
      if (pix_out !== (out_en ? pix_in : 16'h0) ||
          {frm_out, lclk_out, sclk_out, den_out} !==
          (out_en ? {frm_in, lclk_in, sclk_in, den_in} : 4'h0)) begin
        fails++;
        $display("FAIL R6 gate: pix_out=%h expected=%h", pix_out, out_en ? pix_in : 16'h0);
      end
      if (cur !== prev) begin
        if (exp_q.size() == 0) begin
          checks++; fails++;
          $display("FAIL R2 unexpected change: actual=%b expected=%b", cur, prev);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          checks++;
          if (cur !== e.t) begin
            fails++;
            $display("FAIL R%0d step: actual=%b expected=%b", e.r, cur, e.t);
          end
          if (e.d >= 0) begin
            checks++;
            if (ticks - last_tk != e.d) begin
              fails++;
              $display("FAIL R%0d gap: actual=%0d expected=%0d", e.r, ticks - last_tk, e.d);
            end
          end
          // R9 busy
          checks++;
          if (busy !== !(cur == 3'b000 || cur == 3'b111)) begin
            fails++;
            $display("FAIL R9 busy: actual=%b expected=%b", busy, !(cur == 3'b000 || cur == 3'b111));
          end
        end
        last_tk = ticks;
        prev = cur;
      end
    end
    pix_in <= pix_in + 16'h3b1d;
    {frm_in, lclk_in, sclk_in, den_in} <= {frm_in, lclk_in, sclk_in, den_in} + 4'h5;
    if (phase == 3) begin frame_tick <= 1'b1; ticks++; phase = 0; end
    else begin frame_tick <= 1'b0; phase++; end
  end

  task automatic seq_on(input logic [3:0] a, input logic [3:0] b);
    push(3'b001, -1, 2);               // R2 first step
    push(3'b011, a + 1, 3);            // R3
    push(3'b111, b + 1, 4);            // R4
    disp_req = 1'b1;
  endtask

  task automatic seq_off(input logic [3:0] e, input logic [3:0] f);
    push(3'b011, -1, 5);               // R5
    push(3'b001, e + 1, 5);
    push(3'b000, f + 1, 5);
    disp_req = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    checks++;
    if ({drive_pwr_en, out_en, logic_pwr_en, busy} !== 4'b0 || pix_out !== 16'h0 ||
        {frm_out, lclk_out, sclk_out, den_out} !== 4'h0) begin
      fails++;
      $display("FAIL R1 reset: actual=%b expected=0000",
               {drive_pwr_en, out_en, logic_pwr_en, busy});
    end
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    checks++;
    if ({drive_pwr_en, out_en, logic_pwr_en, busy} !== 4'b0) begin
      fails++;
      $display("FAIL R1 idle: actual=%b expected=0000", {drive_pwr_en, out_en, logic_pwr_en, busy});
    end

    seq_periods = 16'h2013; seq_on(4'd2, 4'd0); drain;
    seq_off(4'd1, 4'd3); drain;
    seq_periods = 16'h0500; seq_on(4'd0, 4'd5); drain;
    seq_off(4'd0, 4'd0); drain;
    seq_periods = 16'hffff; seq_on(4'd15, 4'd15); drain;
    seq_off(4'd15, 4'd15); drain;

    // R7: fields change mid-sequence, gaps stay
    seq_periods = 16'h3421; seq_on(4'd3, 4'd4);
    repeat (10) @(negedge clk); seq_periods = 16'h0000; drain;
    seq_periods = 16'h0021; seq_off(4'd2, 4'd1);
    repeat (6) @(negedge clk); seq_periods = 16'hffff; drain;

    // R8: off request during power-on, on request during power-off
    seq_periods = 16'h1122;
    seq_on(4'd1, 4'd1);
    @(negedge clk); @(negedge clk);
    push(3'b011, -1, 8);
    push(3'b001, 3, 8);
    push(3'b000, 3, 8);
    disp_req = 1'b0;
    while (exp_q.size() > 2) @(negedge clk);
    push(3'b001, -1, 8);
    push(3'b011, 2, 8);
    push(3'b111, 2, 8);
    disp_req = 1'b1;
    drain;
    seq_off(4'd2, 4'd2); drain;

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2 pending: actual=%0d expected=0", exp_q.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule